// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory transfer address and the base-register update value for a single load or store. The offset is an immediate or a register value, added to or subtracted from the base. A register offset can be passed through a barrel shifter with an immediate count. Three indexing forms are supported. In plain offset form the computed address is used and the base is left alone. In pre-indexed form the computed address is used and also written back. In post-indexed form the old base is used and the computed sum is written back.

For stores, the block drives little-endian byte-lane enables. For loads, it picks the addressed byte or halfword out of the returned memory word and extends it to 32 bits. A word or halfword access at a misaligned address is flagged and gets no lane enables.

A request is captured on a cycle with `op_en` high. Its results appear at the outputs on the following cycle, marked by `res_valid`. `ld_result` is formed combinationally from the captured request and the current `ld_raw`.

Top module: `ldst_agu`

## Requirements
- R1: With `use_reg`=0 on a word or unsigned-byte access, the offset is the zero-extended 12-bit `imm`. `add_sel`=1 adds the offset to `base` and `add_sel`=0 subtracts it. `wb_data` always carries base±offset.
- R2: With `use_reg`=1 on a word or unsigned-byte access, the offset is `rm` shifted by `sh_amt` according to `sh_type`: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. A count of 0 with right logical gives 0. A count of 0 with right arithmetic gives 32 copies of `rm[31]`.
- R3: With `sh_type`=11 and `sh_amt`=0, the offset is `{carry_in, rm[31:1]}`, a one-bit rotate through the carry.
- R4: Plain offset form (`pre_idx`=1, `wb_req`=0): `xfer_addr` is base±offset and `wb_en` is 0.
- R5: Pre-indexed writeback form (`pre_idx`=1, `wb_req`=1): `xfer_addr` and `wb_data` are both base±offset, and `wb_en` is 1.
- R6: Post-indexed form (`pre_idx`=0): `xfer_addr` is the unmodified `base`, `wb_data` is base±offset, and `wb_en` is 1 whatever `wb_req` is.
- R7: Narrow forms are a halfword access (`acc_size`=01) or a signed byte access (`acc_size`=00 with `acc_signed`=1). For these, the immediate offset is only `imm[7:0]` and a register offset is `rm` unshifted, so `sh_type` and `sh_amt` are ignored.
- R8: An unsigned byte or halfword load returns the lane selected by `xfer_addr[1:0]`, zero-extended to 32 bits. Byte lane n is `ld_raw[8n+7:8n]`; the halfword is the low half when `xfer_addr[1]`=0 and the high half otherwise. A word load (`acc_size`=10 or 11) returns `ld_raw` unchanged.
- R9: A signed byte or halfword load returns the selected lane sign-extended to 32 bits.
- R10: A halfword access with `xfer_addr[0]`=1, or a word access with `xfer_addr[1:0]`≠0, raises `align_err`, and `byte_en` is 0000.
- R11: For an aligned store, `byte_en` bit n enables byte lane n. A byte store enables lane `xfer_addr[1:0]`, a halfword store enables 0011 or 1100, and a word store enables 1111. For loads `byte_en` is 0000.
- R12: Results appear on the cycle after `op_en`. When no request was captured in the previous cycle, and while in reset, `res_valid`, `wb_en` and `byte_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Capture a request this cycle |
| base | input | 32 | Base register value |
| imm | input | 12 | Immediate offset |
| use_reg | input | 1 | 1 selects the register offset |
| rm | input | 32 | Offset register value |
| sh_type | input | 2 | Shift kind for the register offset |
| sh_amt | input | 5 | Shift count |
| carry_in | input | 1 | Carry flag used by the one-bit rotate |
| add_sel | input | 1 | 1 adds, 0 subtracts the offset |
| pre_idx | input | 1 | 1 pre-indexed/offset, 0 post-indexed |
| wb_req | input | 1 | Writeback request in pre-indexed form |
| acc_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| acc_signed | input | 1 | Signed load extension |
| is_store | input | 1 | 1 store, 0 load |
| ld_raw | input | 32 | Word returned by memory |
| xfer_addr | output | 32 | Transfer address |
| wb_data | output | 32 | Base update value |
| wb_en | output | 1 | Base update enable |
| byte_en | output | 4 | Store byte-lane enables |
| align_err | output | 1 | Misaligned access flag |
| ld_result | output | 32 | Extended load data |
| res_valid | output | 1 | Results valid |

## Verification
Offsets are tried in several kinds: small and all-ones immediates, which separate the 12-bit and 8-bit immediate widths, and register values with the sign bit set, which separate arithmetic from logical right shifts. A count of zero is tried on every shifter mode, because that is where right shifts mean 32 and rotate turns into the carry rotate. Each indexing form is run with known base values, so a swapped address and writeback value shows up at once. Loads read one raw word through every lane, with both negative and positive top bits, which separates zero extension from sign extension and shows whether the wrong lane was picked.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRD2 = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;
endpackage

// File: rtl/ldst_agu_shift.sv
module ldst_agu_shift
  import ldst_agu_pkg::*;
#(
  parameter int DW = 32,
  localparam int AW = $clog2(DW)
) (
  input  logic [DW-1:0] val_i,
  input  shift_e        kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          cin_i,
  output logic [DW-1:0] val_o
);
  logic [2*DW-1:0] dbl;

  always_comb begin
    dbl = {val_i, val_i} >> amt_i;
    unique case (kind_i)
      SH_LSL: val_o = val_i << amt_i;
      SH_LSR: val_o = (amt_i == '0) ? '0 : (val_i >> amt_i);
      SH_ASR: val_o = (amt_i == '0) ? {DW{val_i[DW-1]}}
                                    : DW'($signed(val_i) >>> amt_i);
      default: val_o = (amt_i == '0) ? {cin_i, val_i[DW-1:1]} : dbl[DW-1:0];
    endcase
  end
endmodule

// File: rtl/ldst_agu_lanes.sv
module ldst_agu_lanes
  import ldst_agu_pkg::*;
#(
  parameter int LANES = 4,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LW-1:0]    lo_i,
  input  acc_size_e        size_i,
  input  logic             store_i,
  output logic [LANES-1:0] be_o,
  output logic             err_o
);
  logic [LANES-1:0] raw_be;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        err_o  = 1'b0;
        raw_be = LANES'(1) << lo_i;
      end
      SZ_HALF: begin
        err_o  = lo_i[0];
        raw_be = LANES'(2'b11) << {lo_i[LW-1:1], 1'b0};
      end
      default: begin
        err_o  = (lo_i != '0);
        raw_be = '1;
      end
    endcase
    be_o = (store_i && !err_o) ? raw_be : '0;
  end
endmodule

// File: rtl/ldst_agu_extend.sv
module ldst_agu_extend
  import ldst_agu_pkg::*;
#(
  parameter int DW = 32,
  localparam int LW = $clog2(DW / 8)
) (
  input  logic [DW-1:0] raw_i,
  input  logic [LW-1:0] lo_i,
  input  acc_size_e     size_i,
  input  logic          sgn_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] by_sh, hw_sh;

  always_comb begin
    by_sh = raw_i >> {lo_i, 3'b000};
    hw_sh = raw_i >> {lo_i[LW-1], 4'b0000};
    unique case (size_i)
      SZ_BYTE: res_o = sgn_i ? {{(DW-8){by_sh[7]}}, by_sh[7:0]}
                             : {{(DW-8){1'b0}}, by_sh[7:0]};
      SZ_HALF: res_o = sgn_i ? {{(DW-16){hw_sh[15]}}, hw_sh[15:0]}
                             : {{(DW-16){1'b0}}, hw_sh[15:0]};
      default: res_o = raw_i;
    endcase
  end

  always_comb begin
    if (size_i == SZ_BYTE && !sgn_i)
      assert_zero_byte_R8: assert (res_o[DW-1:8] == '0);
    if (size_i == SZ_BYTE && sgn_i)
      assert_sign_byte_R9: assert (res_o[DW-1:8] == {(DW-8){res_o[7]}});
  end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_agu_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMMW  = 12,
  parameter int NIMMW = 8,
  localparam int LANES = DW / 8,
  localparam int LW    = $clog2(LANES),
  localparam int SAW   = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_en,
  input  logic [DW-1:0]    base,
  input  logic [IMMW-1:0]  imm,
  input  logic             use_reg,
  input  logic [DW-1:0]    rm,
  input  logic [1:0]       sh_type,
  input  logic [SAW-1:0]   sh_amt,
  input  logic             carry_in,
  input  logic             add_sel,
  input  logic             pre_idx,
  input  logic             wb_req,
  input  logic [1:0]       acc_size,
  input  logic             acc_signed,
  input  logic             is_store,
  input  logic [DW-1:0]    ld_raw,
  output logic [DW-1:0]    xfer_addr,
  output logic [DW-1:0]    wb_data,
  output logic             wb_en,
  output logic [LANES-1:0] byte_en,
  output logic             align_err,
  output logic [DW-1:0]    ld_result,
  output logic             res_valid
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  acc_size_e size_in;
  logic      narrow;
  logic [DW-1:0] shifted, imm_off, reg_off, offset, sum;
  logic [DW-1:0] addr_d;
  logic          wbe_d;

  assign size_in = acc_size_e'(acc_size);

  ldst_agu_shift #(.DW(DW)) u_shift (
    .val_i (rm),
    .kind_i(shift_e'(sh_type)),
    .amt_i (sh_amt),
    .cin_i (carry_in),
    .val_o (shifted)
  );

  always_comb begin
    narrow  = (size_in == SZ_HALF) || (size_in == SZ_BYTE && acc_signed);
    imm_off = narrow ? DW'(imm[NIMMW-1:0]) : DW'(imm);
    reg_off = narrow ? rm : shifted;
    offset  = use_reg ? reg_off : imm_off;
    sum     = add_sel ? (base + offset) : (base - offset);
    addr_d  = pre_idx ? sum : base;
    wbe_d   = !pre_idx || wb_req;
  end

  // captured request
  logic [DW-1:0] addr_q, wbd_q;
  logic          wbe_q, st_q, sgn_q, vld_q;
  acc_size_e     size_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wbd_q  <= '0;
      wbe_q  <= 1'b0;
      st_q   <= 1'b0;
      sgn_q  <= 1'b0;
      size_q <= SZ_WORD;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= op_en;
      if (op_en) begin
        addr_q <= addr_d;
        wbd_q  <= sum;
        wbe_q  <= wbe_d;
        st_q   <= is_store;
        sgn_q  <= acc_signed;
        size_q <= size_in;
      end
    end
  end

  logic [LANES-1:0] be_raw;
  logic             err_raw;

  ldst_agu_lanes #(.LANES(LANES)) u_lanes (
    .lo_i   (addr_q[LW-1:0]),
    .size_i (size_q),
    .store_i(st_q),
    .be_o   (be_raw),
    .err_o  (err_raw)
  );

  ldst_agu_extend #(.DW(DW)) u_ext (
    .raw_i (ld_raw),
    .lo_i  (addr_q[LW-1:0]),
    .size_i(size_q),
    .sgn_i (sgn_q),
    .res_o (ld_result)
  );

  assign xfer_addr = addr_q;
  assign wb_data   = wbd_q;
  assign res_valid = vld_q;
  assign wb_en     = vld_q & wbe_q;
  assign byte_en   = vld_q ? be_raw : '0;
  assign align_err = vld_q & err_raw;

  // checks
  assert_post_base_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_en && !pre_idx) |=> (wb_en && xfer_addr == $past(base)));

  assert_plain_nowb_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_en && pre_idx && !wb_req) |=> !wb_en);

  assert_pre_same_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_en && pre_idx && wb_req) |=> (wb_en && xfer_addr == wb_data));

  assert_misalign_nolane_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    align_err |-> (byte_en == '0));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    !op_en |=> (!wb_en && byte_en == '0));

  assert_lane_count_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(byte_en) || $countones(byte_en) == 2 || byte_en == '1);
endmodule

// File: tb/ldst_agu_tb_top.sv
module ldst_agu_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, op_en, use_reg, carry_in, add_sel, pre_idx, wb_req;
  logic        acc_signed, is_store;
  logic [31:0] base, rm, ld_raw;
  logic [11:0] imm;
  logic [1:0]  sh_type, acc_size;
  logic [4:0]  sh_amt;
  logic [31:0] xfer_addr, wb_data, ld_result;
  logic        wb_en, align_err, res_valid;
  logic [3:0]  byte_en;

  ldst_agu dut_i (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .base(base), .imm(imm),
    .use_reg(use_reg), .rm(rm), .sh_type(sh_type), .sh_amt(sh_amt),
    .carry_in(carry_in), .add_sel(add_sel), .pre_idx(pre_idx),
    .wb_req(wb_req), .acc_size(acc_size), .acc_signed(acc_signed),
    .is_store(is_store), .ld_raw(ld_raw), .xfer_addr(xfer_addr),
    .wb_data(wb_data), .wb_en(wb_en), .byte_en(byte_en),
    .align_err(align_err), .ld_result(ld_result), .res_valid(res_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] base;
    logic [11:0] imm;
    logic        use_reg;
    logic [31:0] rm;
    logic [1:0]  sht;
    logic [4:0]  sha;
    logic        cin, add, pre, wb;
    logic [1:0]  size;
    logic        sgn, st;
    logic [31:0] e_addr, e_wbd;
    logic        e_wbe;
    logic [3:0]  e_be;
    logic        e_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    // R1 R4 R11: word imm add, plain offset, store
    '{32'h1000, 12'h024, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1,
      32'h1024, 32'h1024, 1'b0, 4'b1111, 1'b0, 4'd1},
    // R5: word imm sub, pre-index writeback, load
    '{32'h1000, 12'h010, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0,
      32'h0FF0, 32'h0FF0, 1'b1, 4'b0000, 1'b0, 4'd5},
    // R6: unsigned byte post-index, full 12-bit imm, wb_req low
    '{32'h2000, 12'hFFF, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1,
      32'h2000, 32'h2FFF, 1'b1, 4'b0001, 1'b0, 4'd6},
    // R2: LSL #2
    '{32'h0100, 12'h000, 1'b1, 32'h3, 2'd0, 5'd2, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1,
      32'h010C, 32'h010C, 1'b0, 4'b1111, 1'b0, 4'd2},
    // R2: LSR count 0 means 32
    '{32'h0200, 12'h000, 1'b1, 32'hFFFFFFFF, 2'd1, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1,
      32'h0200, 32'h0200, 1'b0, 4'b1111, 1'b0, 4'd2},
    // R2 R10: ASR count 0 gives all ones, sub, misaligned word store
    '{32'h0300, 12'h000, 1'b1, 32'h80000000, 2'd2, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1,
      32'h0301, 32'h0301, 1'b0, 4'b0000, 1'b1, 4'd10},
    // R2 R5: ASR #4 with writeback
    '{32'h01000000, 12'h000, 1'b1, 32'hF0000000, 2'd2, 5'd4, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1,
      32'h0, 32'h0, 1'b1, 4'b1111, 1'b0, 4'd2},
    // R2: ROR #8, sub
    '{32'hAB000004, 12'h000, 1'b1, 32'h000000AB, 2'd3, 5'd8, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1,
      32'h4, 32'h4, 1'b0, 4'b1111, 1'b0, 4'd2},
    // R3: carry rotate, carry set
    '{32'h0, 12'h000, 1'b1, 32'h8, 2'd3, 5'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1,
      32'h80000004, 32'h80000004, 1'b0, 4'b1111, 1'b0, 4'd3},
    // R3: carry rotate, carry clear
    '{32'h10, 12'h000, 1'b1, 32'h9, 2'd3, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 1'b1,
      32'h14, 32'h14, 1'b0, 4'b1111, 1'b0, 4'd3},
    // R7 R11: halfword imm uses only low 8 bits, low lanes
    '{32'h0400, 12'hF08, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1,
      32'h0408, 32'h0408, 1'b0, 4'b0011, 1'b0, 4'd7},
    // R7 R11: halfword register offset, shift ignored, high lanes
    '{32'h0400, 12'h000, 1'b1, 32'h6, 2'd0, 5'd3, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1,
      32'h0406, 32'h0406, 1'b0, 4'b1100, 1'b0, 4'd7},
    // R7: signed byte imm 8-bit, sub, load
    '{32'h0500, 12'h1FF, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0,
      32'h0401, 32'h0401, 1'b0, 4'b0000, 1'b0, 4'd7},
    // R10: misaligned halfword store
    '{32'h0401, 12'h000, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1,
      32'h0401, 32'h0401, 1'b0, 4'b0000, 1'b1, 4'd10},
    // R11: byte store lane 3
    '{32'h0500, 12'h003, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1,
      32'h0503, 32'h0503, 1'b0, 4'b1000, 1'b0, 4'd11}
  };

  task automatic issue(logic [31:0] b, logic [11:0] im, logic ur, logic [31:0] r,
                       logic [1:0] sht, logic [4:0] sha, logic ci, logic ad,
                       logic pr, logic w, logic [1:0] sz, logic sg, logic st);
    @(negedge clk);
    base = b; imm = im; use_reg = ur; rm = r; sh_type = sht; sh_amt = sha;
    carry_in = ci; add_sel = ad; pre_idx = pr; wb_req = w; acc_size = sz;
    acc_signed = sg; is_store = st; op_en = 1'b1;
    @(negedge clk);
    op_en = 1'b0;
  endtask

  task automatic load_at(logic [31:0] a, logic [1:0] sz, logic sg, logic [31:0] raw);
    issue(a, 12'h0, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b1, 1'b1, 1'b0, sz, sg, 1'b0);
    ld_raw = raw;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; op_en = 1'b0; base = '0; imm = '0; use_reg = 1'b0; rm = '0;
    sh_type = '0; sh_amt = '0; carry_in = 1'b0; add_sel = 1'b1; pre_idx = 1'b1;
    wb_req = 1'b0; acc_size = 2'b10; acc_signed = 1'b0; is_store = 1'b0; ld_raw = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "reset res_valid", {31'b0, res_valid}, 32'h0);
    check("R12", "reset wb_en", {31'b0, wb_en}, 32'h0);
    check("R12", "reset byte_en", {28'b0, byte_en}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12", "idle res_valid", {31'b0, res_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i].req);
      issue(VEC[i].base, VEC[i].imm, VEC[i].use_reg, VEC[i].rm, VEC[i].sht, VEC[i].sha,
            VEC[i].cin, VEC[i].add, VEC[i].pre, VEC[i].wb, VEC[i].size, VEC[i].sgn, VEC[i].st);
      check(rq, $sformatf("v%0d xfer_addr", i), xfer_addr, VEC[i].e_addr);
      check(rq, $sformatf("v%0d wb_data", i), wb_data, VEC[i].e_wbd);
      check(rq, $sformatf("v%0d wb_en", i), {31'b0, wb_en}, {31'b0, VEC[i].e_wbe});
      check(rq, $sformatf("v%0d byte_en", i), {28'b0, byte_en}, {28'b0, VEC[i].e_be});
      check(rq, $sformatf("v%0d align_err", i), {31'b0, align_err}, {31'b0, VEC[i].e_err});
      check("R12", $sformatf("v%0d res_valid", i), {31'b0, res_valid}, 32'h1);
    end

    // R12: no request captured in the previous cycle
    @(negedge clk);
    check("R12", "after idle res_valid", {31'b0, res_valid}, 32'h0);
    check("R12", "after idle wb_en", {31'b0, wb_en}, 32'h0);
    check("R12", "after idle byte_en", {28'b0, byte_en}, 32'h0);

    // R8: zero extension
    load_at(32'h802, 2'b00, 1'b0, 32'hC3B2A190);
    check("R8", "ubyte lane2", ld_result, 32'h000000B2);
    load_at(32'h800, 2'b01, 1'b0, 32'hC3B2A190);
    check("R8", "uhalf low", ld_result, 32'h0000A190);
    load_at(32'h800, 2'b10, 1'b0, 32'hC3B2A190);
    check("R8", "word", ld_result, 32'hC3B2A190);
    check("R11", "load byte_en", {28'b0, byte_en}, 32'h0);
    // R9: sign extension
    load_at(32'h801, 2'b00, 1'b1, 32'hC3B2A190);
    check("R9", "sbyte lane1 negative", ld_result, 32'hFFFFFFA1);
    load_at(32'h800, 2'b01, 1'b1, 32'hC3B2A190);
    check("R9", "shalf low negative", ld_result, 32'hFFFFA190);
    load_at(32'h803, 2'b00, 1'b1, 32'h7F3480C5);
    check("R9", "sbyte lane3 positive", ld_result, 32'h0000007F);
    load_at(32'h802, 2'b01, 1'b1, 32'h7F3480C5);
    check("R9", "shalf high positive", ld_result, 32'h00007F34);

    // R6: post-index with wb_req high behaves the same
    issue(32'h3000, 12'h004, 1'b0, 32'h0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0);
    check("R6", "post addr", xfer_addr, 32'h3000);
    check("R6", "post wb_data", wb_data, 32'h2FFC);
    check("R6", "post wb_en", {31'b0, wb_en}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule